// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz enable strobe into a programmable periodic event. A 4-bit rate code picks the period as a power of two of strobe ticks. At each period boundary the block sets a sticky periodic flag. When the interrupt enable is on, it also sets a sticky interrupt-request flag. When the square-wave enable is on, it emits a single-cycle pulse.

A free-running prescaler counts every strobe from reset. It is never restarted, so events fall on multiples of the selected period in that count and not at a time relative to when software wrote the code. A separate clear strobe drops both sticky flags. It is meant to be pulsed when software acknowledges the interrupt.

Top module: `periodic_rate_gen`

## Requirements
- R1: After a synchronous active-low reset, `per_flag`, `irq_req` and `sqw_pulse` are all 0 and the prescaler count is 0.
- R2: For rate codes 3 to 15, an event occurs every 2^(code-1) strobe ticks (code 3 gives 4 ticks, code 15 gives 16384 ticks).
- R3: Rate codes 1 and 2 are aliases of codes 8 and 9, giving periods of 128 and 256 ticks.
- R4: Rate code 0 produces no events at all.
- R5: With both `pie_en` and `sqwe_en` low, no events are produced and the flags stay as they were.
- R6: The prescaler advances on every strobe whatever the code and enables. An event occurs on the strobe that brings the count to a multiple of the current period. A change of code therefore takes effect at the next multiple of the new period.
- R7: `per_flag` is set by every event and stays set until it is cleared.
- R8: `irq_req` is set by an event only while `pie_en` is high, and it stays set until it is cleared.
- R9: While `sqwe_en` is high, each event produces a `sqw_pulse` that lasts exactly one clock cycle. The pulse appears in the cycle after the strobe.
- R10: `flag_clr` clears both flags. It takes priority over an event in the same cycle, but the pulse for that event is still emitted.
- R11: Events happen only on clock cycles where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe at the 32768 Hz rate |
| rate_code | input | 4 | Period select; 0 disables the tick |
| pie_en | input | 1 | Periodic interrupt enable |
| sqwe_en | input | 1 | Square-wave pulse enable |
| flag_clr | input | 1 | Clears the periodic and interrupt flags |
| per_flag | output | 1 | Sticky periodic-event flag |
| irq_req | output | 1 | Sticky interrupt request |
| sqw_pulse | output | 1 | One-cycle pulse per event |

## Verification
The tick is driven both back-to-back and with idle cycles between strobes. This separates counting strobes from counting clocks. Short, medium and longest codes, together with the two aliased codes, test the period decode. Pulse counts over fixed windows distinguish the aliases from their nominal periods. Switching the code mid-stream and holding the enables low for a while before turning them on show whether the prescaler is free-running and aligned. Running with only the square-wave enable separates the flag from the interrupt request. Landing a clear exactly on an event cycle shows which one wins.

// File: rtl/pirg_pkg.sv
// Shared defaults and types for the periodic interrupt rate generator.
// Assumes: consumers pick their widths through module parameters that
// default to the values below.
package pirg_pkg;
    localparam int RATE_W_DEF    = 4;   // width of the rate code
    localparam int PRE_W_DEF     = 15;  // prescaler width (32768 ticks per wrap)
    localparam int ALIAS_MAX_DEF = 2;   // highest code that is aliased upward
    localparam int ALIAS_ADD_DEF = 7;   // offset added to aliased codes

    // Registered outputs of the flag stage
    typedef struct packed {
        logic per;
        logic irq;
        logic sqw;
    } pirg_out_t;
endpackage

// File: rtl/pirg_prescaler.sv
// Free-running prescaler counting 32 kHz strobes since reset.
// Assumes: tick_en is a single-cycle strobe. The counter is never restarted
// by code or enable changes, so that period boundaries stay aligned.
module pirg_prescaler #(
    parameter int PRE_W = pirg_pkg::PRE_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [PRE_W-1:0] cnt_nxt
);
    logic [PRE_W-1:0] cnt_q;

    // Value the count takes on this strobe
    always_comb cnt_nxt = cnt_q + PRE_W'(1);

    // Advance on each strobe; wraps naturally at 2^PRE_W
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (tick_en) cnt_q <= cnt_nxt;
    end

    p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (cnt_q == $past(cnt_q) + PRE_W'(1)));
endmodule

// File: rtl/pirg_rate_sel.sv
// Decodes the rate code into a period mask and detects period boundaries.
// Assumes: a period is a power of two of ticks, so a boundary is reached when
// the low bits of the next count are all zero. Low codes are aliased upward.
module pirg_rate_sel #(
    parameter int RATE_W    = pirg_pkg::RATE_W_DEF,
    parameter int PRE_W     = pirg_pkg::PRE_W_DEF,
    parameter int ALIAS_MAX = pirg_pkg::ALIAS_MAX_DEF,
    parameter int ALIAS_ADD = pirg_pkg::ALIAS_ADD_DEF
) (
    input  logic [RATE_W-1:0] rate_code,
    input  logic              pie_en,
    input  logic              sqwe_en,
    input  logic [PRE_W-1:0]  cnt_nxt,
    output logic              hit
);
    localparam logic [RATE_W-1:0] ALIAS_LIM = RATE_W'(ALIAS_MAX);
    localparam logic [RATE_W-1:0] ALIAS_OFS = RATE_W'(ALIAS_ADD);

    logic [RATE_W-1:0] eff_code;
    logic [PRE_W-1:0]  mask;
    logic              active;

    // Fold aliased low codes onto slower rates
    always_comb begin
        if (rate_code != '0 && rate_code <= ALIAS_LIM) eff_code = rate_code + ALIAS_OFS;
        else                                           eff_code = rate_code;
    end

    // Mask of period-1: bit i is set when i < eff_code-1
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = ((i + 1) < int'(eff_code));
    end

    // The tick only runs with a nonzero code and some consumer enabled
    always_comb active = (rate_code != '0) && (pie_en || sqwe_en);

    // Boundary when the masked next count is zero
    always_comb hit = active && ((cnt_nxt & mask) == '0);
endmodule

// File: rtl/pirg_flags.sv
// Sticky periodic and interrupt flags plus the one-cycle square-wave pulse.
// Assumes: evt is a single-cycle event spaced at least a few strobes apart.
// A clear beats a same-cycle set.
module pirg_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic pie_en,
    input  logic sqwe_en,
    input  logic flag_clr,
    output pirg_pkg::pirg_out_t outs
);
    // Flag and pulse registers; clear has priority over set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outs <= '0;
        end else begin
            if (flag_clr)              outs.per <= 1'b0;
            else if (evt)              outs.per <= 1'b1;
            if (flag_clr)              outs.irq <= 1'b0;
            else if (evt && pie_en)    outs.irq <= 1'b1;
            outs.sqw <= evt && sqwe_en;
        end
    end

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        outs.irq |-> outs.per);
    p_clr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!outs.per && !outs.irq));
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        outs.sqw |=> !outs.sqw);
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (outs.per && !flag_clr) |=> outs.per);
endmodule

// File: rtl/periodic_rate_gen.sv
// Periodic interrupt rate generator top. It counts 32 kHz strobes, finds the
// boundaries of the selected power-of-two period and drives sticky flags and
// a pulse.
// Assumes: tick_en is synchronous to clk and lasts one cycle per tick.
module periodic_rate_gen #(
    parameter int RATE_W = pirg_pkg::RATE_W_DEF,
    parameter int PRE_W  = pirg_pkg::PRE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              pie_en,
    input  logic              sqwe_en,
    input  logic              flag_clr,
    output logic              per_flag,
    output logic              irq_req,
    output logic              sqw_pulse
);
    logic [PRE_W-1:0]    cnt_nxt;
    logic                hit;
    logic                evt;
    pirg_pkg::pirg_out_t outs;

    pirg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_nxt(cnt_nxt)
    );

    pirg_rate_sel #(.RATE_W(RATE_W), .PRE_W(PRE_W)) u_sel (
        .rate_code(rate_code), .pie_en(pie_en), .sqwe_en(sqwe_en),
        .cnt_nxt(cnt_nxt), .hit(hit)
    );

    // An event needs a strobe landing on a boundary
    always_comb evt = tick_en && hit;

    pirg_flags u_flags (
        .clk(clk), .rst_n(rst_n), .evt(evt), .pie_en(pie_en),
        .sqwe_en(sqwe_en), .flag_clr(flag_clr), .outs(outs)
    );

    // Unpack the flag stage onto the ports
    always_comb begin
        per_flag  = outs.per;
        irq_req   = outs.irq;
        sqw_pulse = outs.sqw;
    end

    p_code0_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_flag) |-> ($past(rate_code) != '0));
    p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_flag) |-> $past(pie_en || sqwe_en));
    p_pulse_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pulse |-> $past(tick_en));
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(pie_en));
endmodule

// File: tb/periodic_rate_gen_tb.sv
// Directed bench for the periodic interrupt rate generator. It keeps a
// tick-level model of the requirements and compares the outputs every cycle.
module periodic_rate_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       sqwe_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       per_flag, irq_req, sqw_pulse;

    int    n_pass = 0;
    int    n_chk  = 0;
    int    n_fail = 0;
    int    tick_n = 0;      // model of strobes since reset, modulo 32768
    int    pulse_cnt = 0;   // pulses seen at the port
    bit    m_per = 0, m_irq = 0, m_sqw = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;  // 50 MHz

    periodic_rate_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_code(rate_code),
        .pie_en(pie_en), .sqwe_en(sqwe_en), .flag_clr(flag_clr),
        .per_flag(per_flag), .irq_req(irq_req), .sqw_pulse(sqw_pulse)
    );

    function automatic int period_of(input int c);
        if (c == 1) return 128;
        if (c == 2) return 256;
        return 1 << (c - 1);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act == exp) n_pass++;
        else begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_pass, n_chk);
            $finish;
        end
    endtask

    // One clock: drive at negedge, update the model at the edge, compare after
    task automatic step(input bit tk, input bit clr);
        bit evt;
        tick_en  = tk;
        flag_clr = clr;
        @(posedge clk);
        evt = 0;
        if (tk && rate_code != 0 && (pie_en || sqwe_en))
            evt = (((tick_n + 1) % period_of(int'(rate_code))) == 0);
        if (tk) tick_n = (tick_n + 1) % 32768;
        m_sqw = evt && sqwe_en;
        m_per = clr ? 1'b0 : (evt ? 1'b1 : m_per);
        m_irq = clr ? 1'b0 : ((evt && pie_en) ? 1'b1 : m_irq);
        @(negedge clk);
        if (sqw_pulse) pulse_cnt++;
        check(cur_req, "per_flag", int'(per_flag), int'(m_per));
        check(cur_req, "irq_req", int'(irq_req), int'(m_irq));
        check(cur_req, "sqw_pulse", int'(sqw_pulse), int'(m_sqw));
    endtask

    // n strobes with gap idle cycles after each; optionally acknowledge flags
    task automatic run(input int n, input int gap, input bit autoclr);
        for (int i = 0; i < n; i++) begin
            step(1'b1, autoclr && m_per);
            for (int g = 0; g < gap; g++) step(1'b0, 1'b0);
        end
    endtask

    task automatic t_reset_r1();
        cur_req = "R1";
        check("R1", "per_flag", int'(per_flag), 0);
        check("R1", "irq_req", int'(irq_req), 0);
        check("R1", "sqw_pulse", int'(sqw_pulse), 0);
    endtask

    task automatic t_rates_r2();
        cur_req = "R2";
        rate_code = 4'd3; pie_en = 1; sqwe_en = 1;
        pulse_cnt = 0;
        run(64, 0, 1);
        check("R2", "pulses code3/64 ticks", pulse_cnt, 16);
        rate_code = 4'd6; pulse_cnt = 0;
        run(256, 1, 1);                  // R11: strobes with idle cycles
        check("R2", "pulses code6/256 ticks", pulse_cnt, 8);
        rate_code = 4'd15; pulse_cnt = 0;
        run(32768, 0, 1);
        check("R2", "pulses code15/32768 ticks", pulse_cnt, 2);
    endtask

    task automatic t_alias_r3();
        cur_req = "R3";
        rate_code = 4'd1; pie_en = 1; sqwe_en = 1; pulse_cnt = 0;
        run(512, 0, 1);
        check("R3", "pulses code1/512 ticks", pulse_cnt, 4);
        rate_code = 4'd2; pulse_cnt = 0;
        run(512, 0, 1);
        check("R3", "pulses code2/512 ticks", pulse_cnt, 2);
    endtask

    task automatic t_code0_r4();
        cur_req = "R4";
        step(1'b0, 1'b1);
        rate_code = 4'd0; pie_en = 1; sqwe_en = 1; pulse_cnt = 0;
        run(300, 0, 0);
        check("R4", "pulses code0", pulse_cnt, 0);
        check("R4", "per_flag code0", int'(per_flag), 0);
    endtask

    task automatic t_disabled_r5();
        cur_req = "R5";
        rate_code = 4'd3; pie_en = 0; sqwe_en = 0; pulse_cnt = 0;
        run(101, 0, 0);                  // leaves the count off a boundary
        check("R5", "per_flag disabled", int'(per_flag), 0);
        cur_req = "R6";                  // prescaler kept counting meanwhile
        pie_en = 1;
        run(20, 1, 1);
    endtask

    task automatic t_rate_change_r6();
        cur_req = "R6";
        rate_code = 4'd3; pie_en = 1; sqwe_en = 1;
        while ((tick_n % 8) != 4) step(1'b1, m_per);
        rate_code = 4'd4;                // next event at a multiple of 8
        pulse_cnt = 0;
        run(3, 0, 1);
        check("R6", "no pulse before 8-boundary", pulse_cnt, 0);
        run(1, 0, 1);
        check("R6", "pulse on 8-boundary", pulse_cnt, 1);
        run(40, 2, 1);
    endtask

    task automatic t_sticky_irqgate_r7_r8();
        cur_req = "R8";
        step(1'b0, 1'b1);
        rate_code = 4'd3; pie_en = 0; sqwe_en = 1;
        run(12, 0, 0);
        check("R8", "irq with pie off", int'(irq_req), 0);
        cur_req = "R7";
        check("R7", "flag sticky", int'(per_flag), 1);
        run(12, 0, 0);
        pie_en = 1; cur_req = "R8";
        run(8, 0, 0);
        check("R8", "irq with pie on", int'(irq_req), 1);
    endtask

    task automatic t_clear_prio_r10();
        cur_req = "R10";
        rate_code = 4'd3; pie_en = 1; sqwe_en = 1;
        while (((tick_n + 1) % 4) != 0) step(1'b1, 1'b0);
        step(1'b1, 1'b1);                // event and clear together
        check("R10", "per_flag after clr+evt", int'(per_flag), 0);
        check("R10", "irq_req after clr+evt", int'(irq_req), 0);
        check("R9", "pulse despite clr", int'(sqw_pulse), 1);
        step(1'b0, 1'b0);
        check("R9", "pulse one cycle", int'(sqw_pulse), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_rates_r2();
        t_alias_r3();
        t_code0_r4();
        t_disabled_r5();
        t_rate_change_r6();
        t_sticky_irqgate_r7_r8();
        t_clear_prio_r10();
        report();
    end
endmodule